// File: doc/BRIEF.md
# Serially Programmed Eight-Channel Enable Register

This block is a two-wire serial bus target that owns one eight-bit enable register. The register drives eight enable outputs, one per channel, so a bus master can turn any mix of channels on or off with a single write. The same value can be read back over the bus. The block runs on a fast system clock and oversamples the serial clock and data lines. Each line passes through a synchronizer and a run-length filter before the edge and bus-condition detectors see it.

The target answers one seven-bit address. Its top four bits are fixed at `1110` and its low three bits come from the address-select pins. A write may carry any number of data bytes. Each byte replaces the register, and a new value reaches the outputs only at the falling clock edge that ends the acknowledge bit for that byte. A read returns the register MSB first, and sends it again for as long as the master acknowledges.

The control state machine has eight named states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: driving the address acknowledge.
- `ST_WR_DATA`: shifting in a write byte.
- `ST_WR_ACK`: driving the data acknowledge.
- `ST_RD_DATA`: shifting out the register.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: waiting for the next bus condition.

Its transitions are:
- START moves from any state to `ST_ADDR`, and STOP moves from any state to `ST_IDLE`.
- After the eighth address bit, `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_DATA` or `ST_WR_DATA`, depending on the read/write bit.
- `ST_WR_DATA` and `ST_WR_ACK` alternate, one byte at a time.
- `ST_RD_DATA` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` returns to `ST_RD_DATA` if the master acknowledged, and goes to `ST_IGNORE` if it did not.

Top module: `i2c_chan_enable`

## Requirements
- R1: The target acknowledges only the address `{1110, addr_sel_i[2], addr_sel_i[1], addr_sel_i[0]}` followed by the read/write bit (1 = read, 0 = write). On any other address it drives no acknowledge, ignores the data bytes that follow, and leaves the register unchanged.
- R2: In a write, every data byte is acknowledged and loaded into the register. After several bytes the register holds the last one.
- R3: Register bit n drives `chan_en_o[n]`, where 1 means enabled. Any combination of bits may be set.
- R4: A written value appears on `chan_en_o` only after the falling clock edge that ends its acknowledge bit. During the high phase of that acknowledge clock the outputs still show the old value.
- R5: A read returns the register MSB first. After a not-acknowledge from the master, the target releases the data line.
- R6: If the master acknowledges a read byte, the next eight clocks return the same register byte again.
- R7: Asynchronous active-low `rst_n` clears the register to zero, releases the data line and returns the target to idle. A complete transaction after reset is served normally.
- R8: START is data falling while the clock is high, and STOP is data rising while the clock is high. A repeated START at any point restarts address reception and discards any partial byte.
- R9: A pulse on either line shorter than `FILT_LEN` system clocks (default 6, which is 60 ns at 100 MHz) is rejected and does not disturb a transfer.
- R10: The target changes its data-line drive only while the filtered clock is low. An acknowledge is therefore held low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain control) |
| addr_sel_i | input | 3 | Low three address bits |
| chan_en_o | output | 8 | Channel enables, bit n for channel n |

## Verification
Two cases are the hardest to reach from the ports. One is a glitch that arrives at exactly the moment it could be mistaken for a clock edge or a bus condition. The other is a repeated START issued in the middle of a byte. The bench drives every input on the falling system-clock edge, so it controls the exact number of samples a spike occupies. It injects a four-clock clock-line spike in the low phase of the first address bit, and a four-clock data-line inversion in the high phase of a data bit. It also stops a write after four bits to issue a repeated START. The update-timing rule is observed by sampling the enables in the middle of the acknowledge high phase and again after that clock falls.

// File: rtl/i2c_en_pkg.sv
package i2c_en_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_PIN_W = 3;
    localparam int LINE_CNT   = 2;
    localparam int LINE_SDA   = 0;
    localparam int LINE_SCL   = 1;
    localparam logic [3:0] ADDR_PREFIX = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;
endpackage

// File: rtl/i2c_en_filter.sv
module i2c_en_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_r;
    logic [CNT_W-1:0]       run_cnt;
    logic                   sync_out;

    assign sync_out = sync_r[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_r <= '1;
        end else begin
            sync_r <= {sync_r[SYNC_STAGES-2:0], line_i};
        end
    end

    // The filtered level follows the synchronized one only after it has
    // disagreed for FILT_LEN consecutive clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_o  <= 1'b1;
            run_cnt <= '0;
        end else if (sync_out == line_o) begin
            run_cnt <= '0;
        end else if (run_cnt == RUN_LAST) begin
            line_o  <= sync_out;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R9
    filt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |->
            ($past(sync_out) == line_o && $past(sync_out, 2) == line_o));
endmodule

// File: rtl/i2c_en_cond.sv
module i2c_en_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_en_fsm.sv
module i2c_en_fsm
    import i2c_en_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_f,
    input  logic                  sda_f,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [ADDR_PIN_W-1:0] addr_sel_i,
    output logic                  sda_pull_o,
    output logic [BYTE_W-1:0]     chan_en_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] RX_DONE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(BYTE_W - 1);

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_shift;
    logic [BYTE_W-1:0] tx_shift;
    logic [BYTE_W-1:0] ctrl_q;
    logic              mack_q;
    logic              addr_hit;

    assign addr_hit  = (rx_shift[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel_i});
    assign chan_en_o = ctrl_q;

    // Next-state selection
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_cnt == RX_DONE)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = rx_shift[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && bit_cnt == RX_DONE)
                                 state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && bit_cnt == TX_LAST)
                                 state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 state_nx = mack_q ? ST_RD_DATA : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift registers, bit counter and the enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_shift <= '0;
            tx_shift <= '0;
            ctrl_q   <= '0;
            mack_q   <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise) begin
                        rx_shift <= {rx_shift[BYTE_W-2:0], sda_f};
                        bit_cnt  <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == RX_DONE) begin
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rx_shift[0]) tx_shift <= ctrl_q;
                end
                ST_WR_ACK: begin
                    if (scl_fall) ctrl_q <= rx_shift;
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == TX_LAST) begin
                            bit_cnt <= '0;
                        end else begin
                            tx_shift <= {tx_shift[BYTE_W-2:0], 1'b0};
                            bit_cnt  <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_f;
                    else if (scl_fall && mack_q) tx_shift <= ctrl_q;
                end
                ST_IDLE, ST_IGNORE: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end

    // Open-drain output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_o = 1'b1;
            ST_RD_DATA:             sda_pull_o = ~tx_shift[BYTE_W-1];
            default:                sda_pull_o = 1'b0;
        endcase
    end

    // R1
    addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (rx_shift[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel_i}));

    // R4
    en_update_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q != $past(ctrl_q)) |-> ($past(state) == ST_WR_ACK && $past(scl_fall)));

    // R6
    rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_DATA && $past(state) != ST_RD_DATA) |-> (tx_shift == ctrl_q));

    // R8
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R10
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det))
            |-> (sda_pull_o == $past(sda_pull_o)));
endmodule

// File: rtl/i2c_chan_enable.sv
module i2c_chan_enable
    import i2c_en_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    input  logic [ADDR_PIN_W-1:0] addr_sel_i,
    output logic [BYTE_W-1:0]     chan_en_o
);
    logic [LINE_CNT-1:0] raw_lines;
    logic [LINE_CNT-1:0] clean_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
        i2c_en_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2c_en_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (clean_lines[LINE_SCL]),
        .sda_f     (clean_lines[LINE_SDA]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_en_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (clean_lines[LINE_SCL]),
        .sda_f      (clean_lines[LINE_SDA]),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_sel_i (addr_sel_i),
        .sda_pull_o (sda_pull_o),
        .chan_en_o  (chan_en_o)
    );

    // R9
    no_cond_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: tb/test_i2c_chan_enable.sv
module test_i2c_chan_enable;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 25;
    localparam logic [7:0] ADDR_W = 8'hEA;   // 1110_101_0
    localparam logic [7:0] ADDR_R = 8'hEB;   // 1110_101_1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_sel = 3'b101;
    logic       sda_pull;
    logic [7:0] chan_en;
    logic       sda_line;
    logic [7:0] en_at_ack;
    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_chan_enable i_i2c_chan_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .addr_sel_i (addr_sel),
        .chan_en_o  (chan_en)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    // glitch_idx selects a bit (7..0) whose high phase receives a short data-line inversion
    task automatic send_byte(input logic [7:0] b, input int glitch_idx, output logic ack);
        logic early, late;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1;
            if (i == glitch_idx) begin
                repeat (5) @(negedge clk);
                sda_m = ~b[i];
                repeat (4) @(negedge clk);
                sda_m = b[i];
                repeat (Q - 9) @(negedge clk);
            end else begin
                wait_q();
            end
            wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1;
        @(negedge clk);
        early = ~sda_line;
        repeat (Q - 1) @(negedge clk);
        en_at_ack = chan_en;
        repeat (Q - 1) @(negedge clk);
        late = ~sda_line;
        @(negedge clk);
        scl_m = 1'b0; wait_q();
        ack = early & late;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_m = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = ~give_ack; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic put_bit(input logic v);
        sda_m = v; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic write_reg(input logic [7:0] v);
        logic a;
        bus_start();
        send_byte(ADDR_W, -1, a);
        send_byte(v, -1, a);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R7", "enables after reset", chan_en, 8'h00);
        chk("R7", "data line released after reset", sda_pull, 1'b0);
    endtask

    task automatic t_write_one();
        logic a;
        bus_start();
        send_byte(ADDR_W, -1, a);
        chk("R1", "address ack", a, 1'b1);
        send_byte(8'h4C, -1, a);
        chk("R2", "data ack", a, 1'b1);
        chk("R4", "enables during ack clock high", en_at_ack, 8'h00);
        chk("R4", "enables after ack clock falls", chan_en, 8'h4C);
        send_byte(8'h01, -1, a);
        chk("R3", "bit 0 drives channel 0", chan_en[0], 1'b1);
        chk("R3", "only channel 0 on", chan_en, 8'h01);
        send_byte(8'h80, -1, a);
        chk("R3", "bit 7 drives channel 7", chan_en, 8'h80);
        bus_stop();
        chk("R3", "enables held after stop", chan_en, 8'h80);
    endtask

    task automatic t_last_wins();
        logic a;
        logic [7:0] seq [3] = '{8'h11, 8'hA5, 8'h3C};
        bus_start();
        send_byte(ADDR_W, -1, a);
        foreach (seq[k]) begin
            send_byte(seq[k], -1, a);
            chk("R2", "multi-byte ack", a, 1'b1);
            chk("R2", "value after byte", chan_en, seq[k]);
        end
        bus_stop();
        chk("R2", "last byte kept", chan_en, 8'h3C);
    endtask

    task automatic t_read_nack();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(ADDR_R, -1, a);
        chk("R1", "read address ack", a, 1'b1);
        recv_byte(1'b0, d);
        chk("R5", "read data MSB first", d, 8'h3C);
        chk("R5", "released after master nack", sda_pull, 1'b0);
        bus_stop();
        chk("R5", "released after stop", sda_pull, 1'b0);
    endtask

    task automatic t_read_ack();
        logic a;
        logic [7:0] d;
        write_reg(8'hC3);
        bus_start();
        send_byte(ADDR_R, -1, a);
        recv_byte(1'b1, d);
        chk("R6", "first read byte", d, 8'hC3);
        recv_byte(1'b0, d);
        chk("R6", "repeat read byte", d, 8'hC3);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'hE8, -1, a);
        chk("R1", "no ack for wrong select bits", a, 1'b0);
        send_byte(8'hFF, -1, a);
        chk("R1", "no ack for data after mismatch", a, 1'b0);
        bus_stop();
        chk("R1", "register untouched by mismatch", chan_en, 8'hC3);
        bus_start();
        send_byte(8'h6A, -1, a);
        chk("R1", "no ack for wrong fixed bits", a, 1'b0);
        bus_stop();
    endtask

    task automatic t_rep_start();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(ADDR_W, -1, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start();
        send_byte(ADDR_W, -1, a);
        chk("R8", "ack after repeated start", a, 1'b1);
        send_byte(8'h5A, -1, a);
        bus_stop();
        chk("R8", "partial byte discarded, new byte kept", chan_en, 8'h5A);
        bus_start();
        send_byte(8'hE4, -1, a);
        bus_start();
        send_byte(ADDR_R, -1, a);
        chk("R8", "ack after restart from ignore", a, 1'b1);
        recv_byte(1'b0, d);
        chk("R8", "read after restart", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_spike();
        logic a;
        bus_start();
        scl_m = 1'b1; repeat (4) @(negedge clk); scl_m = 1'b0;
        send_byte(ADDR_W, -1, a);
        chk("R9", "ack despite clock spike", a, 1'b1);
        send_byte(8'h96, 3, a);
        chk("R9", "data ack despite data spike", a, 1'b1);
        bus_stop();
        chk("R9", "value intact despite spikes", chan_en, 8'h96);
    endtask

    task automatic t_async_reset();
        logic a;
        bus_start();
        send_byte(ADDR_W, -1, a);
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", "enables cleared during reset", chan_en, 8'h00);
        chk("R7", "data line released during reset", sda_pull, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        scl_m = 1'b1; sda_m = 1'b1; wait_q(); wait_q();
        chk("R7", "enables zero after reset", chan_en, 8'h00);
        write_reg(8'h24);
        chk("R7", "write served after reset", chan_en, 8'h24);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        t_reset();
        t_write_one();
        t_last_wins();
        t_read_nack();
        t_read_ack();
        t_mismatch();
        t_rep_start();
        t_spike();
        t_async_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule